// File: doc/BRIEF.md
# Power-on strap sampling controller

This block runs a small group of dual-role pads. After power comes up, each pad is first read as a configuration input. Later the same pad drives a clock output. A power-good input rises once the supply has crossed its threshold, and that edge starts a sampling window of fixed length, counted in reference clock cycles. For the whole window the pad drivers stay off. This lets the external pull resistor on each pad set its level. The pad levels pass through a two-flop synchronizer. On the reference edge where the window expires, the synchronized levels are captured into configuration bits. The drivers turn on one cycle later. Each clock then reaches its pad only from a point where that clock is low.

Power-good is the block's only reset. When it is low, the block goes back to the sampling state. In that state the pads are off, the configuration bits are zero and the valid flag is clear. The next rise of power-good starts a full new window. No other input can clear or change the captured bits.

The clock sources are expected to be derived from the reference clock. They change only just after its rising edges.

Top module: `strap_sampler`

## Requirements
- R1: While `pwrGood` is low, `padOe`, `padOut`, `cfgBits` and `cfgValid` are all zero.
- R2: After `pwrGood` rises, `cfgValid` stays low for the first WINDOW_CYCLES-1 rising edges of `refClk`. It becomes high right after edge number WINDOW_CYCLES.
- R3: `cfgBits[i]` equals the level of `padIn[i]` at capture, with 1 for a pad pulled high and 0 for a pad pulled low. This holds when the pad is stable for at least two cycles before the window ends.
- R4: Once `cfgValid` is high, changes on `padIn` have no effect on `cfgBits`.
- R5: `padOe` is all zeros while `cfgValid` is low. It becomes all ones right after the edge that follows the one that set `cfgValid`.
- R6: A rise on `padOut[i]` occurs only together with a rise on `clkSrc[i]`, so the first pulse on a pad is always a complete pulse. Within a few cycles of the drivers turning on, `padOut` equals `clkSrc`.
- R7: Dropping `pwrGood` at any point, whether inside the window or after it, clears the captured state. The next rise of `pwrGood` runs a complete new window that picks up the new pad levels.
- R8: While `pwrGood` stays high after capture, `cfgValid` remains high and `cfgBits` never changes.
- R9: `padOut` is zero whenever `padOe` is zero, even while the clock sources toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock for the window timer |
| pwrGood | input | 1 | Supply-good indication, active high; its low level is the only reset |
| padIn | input | NUM_PINS | Level seen on each dual-role pad |
| clkSrc | input | NUM_PINS | Clock to be sent to each pad once the window is over |
| padOut | output | NUM_PINS | Value driven onto each pad |
| padOe | output | NUM_PINS | Pad driver enable, 1 = drive |
| cfgBits | output | NUM_PINS | Captured configuration bits |
| cfgValid | output | 1 | Configuration bits are valid |

## Verification
A timer that counts wrongly shows up at the ports as `cfgValid` rising on the wrong edge after `pwrGood`. Each window is checked on the exact edge, so an error of a single cycle is caught in the first window. A capture latch that is wrong or still open shows up as `cfgBits` that disagree with the strap pattern, or that follow `padIn` after the window. This shows on the first vector or within a few cycles of a pad change. A gate flop that opens in the wrong phase produces a `padOut` rise with no matching `clkSrc` rise. This is visible within the first clock period after the drivers turn on.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE  = 2'd0,
    ST_LATCHED = 2'd1,
    ST_DRIVE   = 2'd2
  } strapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // one-cycle pulse on the last window edge
    logic drive;    // level: pad drivers may be enabled
  } strapStrobe_t;

endpackage

// File: rtl/strap_ctl.sv
module strap_ctl
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic         refClk,
  input  logic         pwrGood,
  output strapStrobe_t strobe
);

  localparam int unsigned CNT_W = (WINDOW_CYCLES < 2) ? 1 : $clog2(WINDOW_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);

  strapState_t     state;
  logic [CNT_W-1:0] winCnt;
  logic            lastEdge;

  assign lastEdge = (state == ST_SAMPLE) && (winCnt == LAST_CNT);

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood) begin
      state  <= ST_SAMPLE;
      winCnt <= '0;
    end else begin
      unique case (state)
        ST_SAMPLE: begin
          if (lastEdge) state  <= ST_LATCHED;
          else          winCnt <= winCnt + 1'b1;
        end
        ST_LATCHED: state <= ST_DRIVE;
        ST_DRIVE:   state <= ST_DRIVE;   // counter stays saturated
        default:    state <= ST_SAMPLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = lastEdge;
    strobe.drive   = (state == ST_DRIVE);
  end

endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int unsigned NUM_PINS = 5
) (
  input  logic                refClk,
  input  logic                pwrGood,
  input  strapStrobe_t        strobe,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] clkSrc,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] cfgBits,
  output logic                cfgValid
);

  logic [NUM_PINS-1:0] syncA, syncB, gateOpen;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // two-flop synchronizer on the strap level
    always_ff @(posedge refClk or negedge pwrGood) begin
      if (!pwrGood) begin
        syncA[i] <= 1'b0;
        syncB[i] <= 1'b0;
      end else begin
        syncA[i] <= padIn[i];
        syncB[i] <= syncA[i];
      end
    end

    // capture latch, written only on the window strobe
    always_ff @(posedge refClk or negedge pwrGood) begin
      if (!pwrGood)           cfgBits[i] <= 1'b0;
      else if (strobe.capture) cfgBits[i] <= syncB[i];
    end

    // gate opens only on an edge where the source is low
    always_ff @(posedge refClk or negedge pwrGood) begin
      if (!pwrGood)                          gateOpen[i] <= 1'b0;
      else if (strobe.drive && !clkSrc[i])   gateOpen[i] <= 1'b1;
    end

    assign padOe[i]  = strobe.drive;
    assign padOut[i] = strobe.drive & gateOpen[i] & clkSrc[i];
  end

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood)           cfgValid <= 1'b0;
    else if (strobe.capture) cfgValid <= 1'b1;
  end

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 5,
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic                refClk,
  input  logic                pwrGood,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] clkSrc,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] cfgBits,
  output logic                cfgValid
);

  strapStrobe_t strobe;

  strap_ctl #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_ctl (
    .refClk  (refClk),
    .pwrGood (pwrGood),
    .strobe  (strobe)
  );

  strap_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .refClk   (refClk),
    .pwrGood  (pwrGood),
    .strobe   (strobe),
    .padIn    (padIn),
    .clkSrc   (clkSrc),
    .padOut   (padOut),
    .padOe    (padOe),
    .cfgBits  (cfgBits),
    .cfgValid (cfgValid)
  );

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk #(
  parameter int unsigned NUM_PINS      = 5,
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input logic                refClk,
  input logic                pwrGood,
  input logic [NUM_PINS-1:0] clkSrc,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] cfgBits,
  input logic                cfgValid
);

  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 2);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // edges since power-good rose, counted while not yet valid
  logic [CW-1:0] sinceUp;
  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood)                         sinceUp <= '0;
    else if (!cfgValid && sinceUp != CNT_MAX) sinceUp <= sinceUp + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge refClk)
    !pwrGood |-> (padOe == '0 && padOut == '0 && cfgBits == '0 && !cfgValid));

  p_window_len_r2: assert property (@(posedge refClk) disable iff (!pwrGood)
    $rose(cfgValid) |-> (sinceUp == CW'(WINDOW_CYCLES)));

  p_oe_quiet_r5: assert property (@(posedge refClk) disable iff (!pwrGood)
    !cfgValid |-> (padOe == '0));

  p_oe_late_r5: assert property (@(posedge refClk) disable iff (!pwrGood)
    $rose(padOe[0]) |-> $past(cfgValid));

  p_bits_hold_r8: assert property (@(posedge refClk) disable iff (!pwrGood)
    cfgValid |=> (cfgValid && $stable(cfgBits)));

  p_idle_out_r9: assert property (@(posedge refClk) disable iff (!pwrGood)
    (padOe == '0) |-> (padOut == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    p_no_runt_r6: assert property (@(posedge refClk) disable iff (!pwrGood)
      $rose(padOut[i]) |-> $rose(clkSrc[i]));
  end

endmodule

bind strap_sampler strap_sampler_chk #(
  .NUM_PINS      (NUM_PINS),
  .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
  .refClk   (refClk),
  .pwrGood  (pwrGood),
  .clkSrc   (clkSrc),
  .padOut   (padOut),
  .padOe    (padOe),
  .cfgBits  (cfgBits),
  .cfgValid (cfgValid)
);

// File: tb/strap_sampler_test.sv
`timescale 1ns/1ps
module strap_sampler_test;

  localparam int N = 5;
  localparam int W = 20;

  logic         refClk = 1'b0;
  logic         pwrGood = 1'b0;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] clkSrc;
  logic [N-1:0] padOut, padOe, cfgBits;
  logic         cfgValid;
  logic [2:0]   phase = '0;

  int total = 0;
  int bad   = 0;

  always #2.5 refClk = ~refClk;   // 200 MHz

  // clock sources derived from the reference, changing just after rising edges
  always @(posedge refClk) phase <= phase + 3'd1;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign clkSrc[i] = ((phase + 3'(i)) & 3'b010) != 3'b000;
  end

  strap_sampler #(.NUM_PINS(N), .WINDOW_CYCLES(W)) uut (
    .refClk(refClk), .pwrGood(pwrGood), .padIn(padIn), .clkSrc(clkSrc),
    .padOut(padOut), .padOe(padOe), .cfgBits(cfgBits), .cfgValid(cfgValid)
  );

  // each entry: strap pattern in [9:5], expected bits in [4:0]
  localparam logic [9:0] VEC [6] = '{
    {5'b00000, 5'b00000}, {5'b11111, 5'b11111}, {5'b10101, 5'b10101},
    {5'b01010, 5'b01010}, {5'b00110, 5'b00110}, {5'b10000, 5'b10000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  task automatic powerUp(input logic [N-1:0] pat);
    @(negedge refClk);
    pwrGood = 1'b0;
    padIn   = pat;
    @(negedge refClk);
    pwrGood = 1'b1;
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R1: reset state
    #1;
    edges(3);
    check(padOe == '0 && padOut == '0 && cfgBits == '0 && !cfgValid, "R1 quiet in reset",
          {padOe, padOut, cfgBits, cfgValid}, 0);

    // vector loop: R2, R3, R5, R4, R8
    for (int v = 0; v < 6; v++) begin
      logic [N-1:0] pat = VEC[v][9:5];
      logic [N-1:0] exp = VEC[v][4:0];
      powerUp(pat);
      edges(W - 1);
      check(!cfgValid, "R2 not valid before window end", 32'(cfgValid), 0);
      check(padOe == '0 && padOut == '0, "R9 quiet during window", {padOe, padOut}, 0);
      edges(1);
      check(cfgValid, "R2 valid at window end", 32'(cfgValid), 1);
      check(cfgBits == exp, "R3 captured bits", cfgBits, exp);
      check(padOe == '0, "R5 drivers still off", padOe, 0);
      edges(1);
      check(padOe == '1, "R5 drivers on", padOe, {N{1'b1}});
      padIn = ~pat;
      edges(6);
      check(cfgBits == exp, "R4 pad change ignored", cfgBits, exp);
    end

    // R6: no runt pulse, then full pass-through
    powerUp(5'b01101);
    edges(W + 1);
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] prevOut = padOut;
      logic [N-1:0] prevClk = clkSrc;
      edges(1);
      for (int i = 0; i < N; i++) begin
        if (padOut[i] && !prevOut[i])
          check(!prevClk[i] && clkSrc[i], "R6 first pulse whole", {prevClk[i], clkSrc[i]}, 2'b01);
      end
    end
    check(padOut == clkSrc, "R6 pass-through", padOut, clkSrc);

    // R8: long hold with pads toggling
    for (int k = 0; k < 8; k++) begin
      padIn = padIn ^ 5'b10011;
      edges(7);
    end
    check(cfgValid && cfgBits == 5'b01101, "R8 bits held", {cfgValid, cfgBits}, {1'b1, 5'b01101});

    // R7: drop after capture clears
    @(negedge refClk); pwrGood = 1'b0;
    #1;
    check(padOe == '0 && cfgBits == '0 && !cfgValid && padOut == '0, "R7 drop clears",
          {padOe, cfgBits, cfgValid}, 0);

    // R7: drop mid-window, then full new window with new pattern
    powerUp(5'b11000);
    edges(10);
    @(negedge refClk); pwrGood = 1'b0;
    #1;
    check(!cfgValid && padOe == '0, "R7 mid-window drop", {cfgValid, padOe}, 0);
    powerUp(5'b00011);
    edges(W - 1);
    check(!cfgValid, "R7 restart full window", 32'(cfgValid), 0);
    edges(1);
    check(cfgValid && cfgBits == 5'b00011, "R7 new capture", {cfgValid, cfgBits}, {1'b1, 5'b00011});

    finishRun();
  end

endmodule